// File: doc/BRIEF.md
# Adaptive Subblock Fetch-Size Line Controller

This block is the control logic for one line of a sectored coherent cache. The line holds a fixed number of 32-bit words. Each word keeps its own four-state coherence state (invalid, shared, exclusive, modified). The line as a whole keeps a block attribute, a current fetch size of 2^k words and a small saturating confidence counter. Tag lookup, data storage, bus arbitration and memory are outside the block.

When the local processor misses on a word, the controller computes the naturally aligned subblock of the current size that contains that word. It then issues one gather request whose word mask names only the words of that subblock that are still invalid, so the missing words can come from several sources. A refill strobe completes the request and installs the words as exclusive or shared. A local write to a shared word produces a one-word invalidate and makes the word modified.

Snooped reads and invalidates change the word states. When a snoop hits the line, the controller also classifies it as a vote to grow or to shrink the fetch size. Votes in a consistent direction build confidence. Only a saturated counter lets k move by one step, which gives the fetch size hysteresis.

Top module: `subfetch_line`

## Requirements
- R1: After synchronous reset every word is invalid (0), blk_attr is invalid (0), sub_k is 1, conf is 0, fetch_busy is 0 and req_valid and inv_valid are 0.
- R2: A local access (read or write) to an invalid word that is accepted raises req_valid for exactly one cycle on the next cycle. req_base is the word index with its low sub_k bits cleared. req_mask has bit j set only for words j in [req_base, req_base+2^sub_k) that are invalid. fetch_busy is set from the same cycle.
- R3: A local access is ignored (no request, no invalidate, no state change) while fetch_busy is 1 or when snp_valid is high in the same cycle.
- R4: While fetch_busy is 1, fill_valid turns every requested word into exclusive (2) if fill_shared is 0, or shared (1) if it is 1, and clears fetch_busy. fill_valid while not busy is ignored.
- R5: An accepted local write to a shared word makes it modified (3) and pulses inv_valid for one cycle on the next cycle, with inv_idx set to that word. A write to an exclusive or modified word makes it modified with no pulse. A read hit changes nothing.
- R6: A snooped invalidate (snp_inv=1) makes every word in snp_mask invalid. A snooped read makes every valid word in snp_mask shared. A snoop overrides a refill of the same word in the same cycle. Word j is reported in word_state[2j+1:2j] with invalid=0, shared=1, exclusive=2, modified=3.
- R7: blk_attr (invalid=0, shared=1, exclusive=2) is invalid exactly when every word is invalid. A snooped read that hits a valid word makes it shared. A refill makes it shared if fill_shared is 1 or it was already shared, and exclusive otherwise.
- R8: A snoop votes only if some word in snp_mask is valid. It is a shrink vote if snp_mask has a bit outside the aligned 2^sub_k subblock containing snp_idx. Otherwise it is a grow vote if snp_mask covers that whole subblock. Otherwise it casts no vote.
- R9: A vote in the same direction as the last one (shrink after reset) increments conf up to 3. A same-direction vote at conf 3 moves sub_k one step in that direction, limited to 0..3, and clears conf. A vote in the opposite direction clears conf and records the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local access strobe |
| loc_write | input | 1 | Local access is a write |
| loc_idx | input | 3 | Word index of the local access |
| snp_valid | input | 1 | Snooped external access strobe |
| snp_inv | input | 1 | Snoop is an invalidate (1) or a read (0) |
| snp_idx | input | 3 | Word the external access is centred on |
| snp_mask | input | 8 | Words touched by the external access |
| fill_valid | input | 1 | Refill of the outstanding request completes |
| fill_shared | input | 1 | Another cache signalled it shares the refilled words |
| req_valid | output | 1 | Gather request pulse |
| req_base | output | 3 | First word of the requested subblock |
| req_mask | output | 8 | Words to be gathered |
| inv_valid | output | 1 | One-word invalidate pulse for a write upgrade |
| inv_idx | output | 3 | Word to invalidate in other caches |
| fetch_busy | output | 1 | A gather request is outstanding |
| word_state | output | 16 | Per-word coherence states, 2 bits each |
| blk_attr | output | 2 | Block-level attribute |
| sub_k | output | 2 | log2 of the current fetch size in words |
| conf | output | 2 | Hysteresis confidence counter |

## Verification
Every result here is registered once. Word states, blk_attr, sub_k, conf and fetch_busy take their new value at the first rising edge after the stimulus. The req and inv pulses are high for the cycle that follows that edge. The bench applies one set of inputs per cycle, away from the edge. It advances its own arithmetic model of the rules by one step and compares every output at the next falling edge, which is the single cycle in which the pulses are due. The stimulus sweeps long mixed sequences of local accesses, refills and snoops, with phases biased toward grow and shrink votes and periodic resets, so that every fetch size and every collision of refill, snoop and local access occurs.

// File: rtl/subfetch_pkg.sv
package subfetch_pkg;

    typedef enum logic [1:0] {
        W_I = 2'd0,
        W_S = 2'd1,
        W_E = 2'd2,
        W_M = 2'd3
    } wstate_e;

    typedef enum logic [1:0] {
        B_INV = 2'd0,
        B_SHR = 2'd1,
        B_EXC = 2'd2
    } battr_e;

    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_SHRINK = 2'd1,
        V_GROW   = 2'd2
    } vote_e;

    // Contiguous run of len ones starting at bit base (lines up to 64 words).
    function automatic logic [63:0] span_bits(input int unsigned base, input int unsigned len);
        logic [63:0] m;
        m = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i >= base && i < base + len) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/subblock_sizer.sv
module subblock_sizer
    import subfetch_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int CONF_W = 2,
    parameter int K_INIT = 1,
    localparam int IW = $clog2(WORDS),
    localparam int KW = $clog2(IW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_hit,
    input  logic [IW-1:0]     snp_idx,
    input  logic [WORDS-1:0]  snp_mask,
    output logic [KW-1:0]     k_q,
    output logic [CONF_W-1:0] conf_q
);
    localparam int K_MAX    = IW;
    localparam int CONF_MAX = (1 << CONF_W) - 1;

    logic              last_grow_q;
    logic [IW-1:0]     sub_base;
    logic [WORDS-1:0]  sub_span;
    vote_e             vote;

    always_comb begin
        sub_base = snp_idx & ~IW'((32'd1 << k_q) - 32'd1);
        sub_span = WORDS'(span_bits(int'(sub_base), 32'd1 << k_q));
        if (!snp_hit)
            vote = V_NONE;
        else if (|(snp_mask & ~sub_span))
            vote = V_SHRINK;
        else if ((snp_mask & sub_span) == sub_span)
            vote = V_GROW;
        else
            vote = V_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q         <= KW'(K_INIT);
            conf_q      <= '0;
            last_grow_q <= 1'b0;
        end else if (vote != V_NONE) begin
            if ((vote == V_GROW) == last_grow_q) begin
                if (conf_q == CONF_W'(CONF_MAX)) begin
                    conf_q <= '0;
                    if (vote == V_GROW && k_q < KW'(K_MAX))
                        k_q <= k_q + KW'(1);
                    else if (vote == V_SHRINK && k_q != '0)
                        k_q <= k_q - KW'(1);
                end else begin
                    conf_q <= conf_q + CONF_W'(1);
                end
            end else begin
                conf_q      <= '0;
                last_grow_q <= (vote == V_GROW);
            end
        end
    end

    // R9: the fetch size only moves after confidence has saturated
    a_r9_step_needs_conf: assert property (@(posedge clk) disable iff (rst)
        (k_q != $past(k_q)) |-> ($past(conf_q) == CONF_W'(CONF_MAX)));

    // R9: one step at a time
    a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
        (k_q != $past(k_q)) |-> (k_q == $past(k_q) + KW'(1) || k_q == $past(k_q) - KW'(1)));

    // R9: size stays within the line
    a_r9_k_in_range: assert property (@(posedge clk) disable iff (rst)
        k_q <= KW'(K_MAX));

    // R8: a snoop that hits nothing leaves the counter alone
    a_r8_miss_no_vote: assert property (@(posedge clk) disable iff (rst)
        !snp_hit |=> ($stable(conf_q) && $stable(k_q)));

endmodule

// File: rtl/fetch_gather.sv
module fetch_gather
    import subfetch_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IW = $clog2(WORDS),
    localparam int KW = $clog2(IW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_go,
    input  logic [IW-1:0]    miss_idx,
    input  logic [KW-1:0]    k,
    input  logic [WORDS-1:0] inval_vec,
    input  logic             fill_valid,
    output logic             fill_go,
    output logic             busy_q,
    output logic [WORDS-1:0] pend_q,
    output logic             req_valid_q,
    output logic [IW-1:0]    req_base_q,
    output logic [WORDS-1:0] req_mask_q
);
    logic [IW-1:0]    base;
    logic [WORDS-1:0] span;
    logic [WORDS-1:0] gather;

    always_comb begin
        base   = miss_idx & ~IW'((32'd1 << k) - 32'd1);
        span   = WORDS'(span_bits(int'(base), 32'd1 << k));
        gather = span & inval_vec;
    end

    assign fill_go = fill_valid && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            pend_q      <= '0;
            req_valid_q <= 1'b0;
            req_base_q  <= '0;
            req_mask_q  <= '0;
        end else begin
            req_valid_q <= 1'b0;
            if (miss_go) begin
                req_valid_q <= 1'b1;
                req_base_q  <= base;
                req_mask_q  <= gather;
                pend_q      <= gather;
                busy_q      <= 1'b1;
            end else if (fill_go) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R2: a request names at least one word, all inside its aligned subblock
    a_r2_mask_inside: assert property (@(posedge clk) disable iff (rst)
        req_valid_q |-> (req_mask_q != '0 &&
            (req_mask_q & ~WORDS'(span_bits(int'(req_base_q), 32'd1 << k))) == '0));

    // R2: the request is a single-cycle pulse
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (rst)
        req_valid_q |=> !req_valid_q);

    // R4: outstanding request stays until its refill
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !fill_valid) |=> busy_q);

endmodule

// File: rtl/line_state_array.sv
module line_state_array
    import subfetch_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_go,
    input  logic [IW-1:0]      wr_idx,
    input  logic               fill_go,
    input  logic [WORDS-1:0]   fill_mask,
    input  logic               fill_shared,
    input  logic               snp_valid,
    input  logic               snp_inv,
    input  logic [WORDS-1:0]   snp_mask,
    output logic [2*WORDS-1:0] st_flat,
    output logic [WORDS-1:0]   valid_vec,
    output logic               snp_hit,
    output battr_e             attr_q
);
    logic [WORDS-1:0] next_valid;
    battr_e           attr_d;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [1:0] q;
        logic [1:0] d;

        always_comb begin
            d = q;
            if (wr_go && wr_idx == IW'(g))
                d = W_M;
            if (fill_go && fill_mask[g])
                d = fill_shared ? W_S : W_E;
            if (snp_valid && snp_mask[g]) begin
                if (snp_inv)
                    d = W_I;
                else if (d != W_I)
                    d = W_S;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) q <= W_I;
            else     q <= d;
        end

        assign st_flat[2*g +: 2] = q;
        assign valid_vec[g]      = (q != W_I);
        assign next_valid[g]     = (d != W_I);
    end

    assign snp_hit = snp_valid && |(snp_mask & valid_vec);

    always_comb begin
        attr_d = attr_q;
        if (fill_go)
            attr_d = (fill_shared || attr_q == B_SHR) ? B_SHR : B_EXC;
        if (snp_hit && !snp_inv)
            attr_d = B_SHR;
        if (next_valid == '0)
            attr_d = B_INV;
    end

    always_ff @(posedge clk) begin
        if (rst) attr_q <= B_INV;
        else     attr_q <= attr_d;
    end

    // R6: snooped invalidate leaves no targeted word valid
    a_r6_inv_clears: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_inv) |=> ((valid_vec & $past(snp_mask)) == '0));

    // R7: block attribute is invalid exactly when the line is empty
    a_r7_attr_tracks_words: assert property (@(posedge clk) disable iff (rst)
        (attr_q == B_INV) == (valid_vec == '0));

    // R4: refilled words become valid unless a snoop intervened
    a_r4_fill_installs: assert property (@(posedge clk) disable iff (rst)
        (fill_go && !snp_valid) |=> ((valid_vec & $past(fill_mask)) == $past(fill_mask)));

endmodule

// File: rtl/subfetch_line.sv
module subfetch_line
    import subfetch_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int CONF_W = 2,
    parameter int K_INIT = 1,
    localparam int IW = $clog2(WORDS),
    localparam int KW = $clog2(IW + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               loc_valid,
    input  logic               loc_write,
    input  logic [IW-1:0]      loc_idx,
    input  logic               snp_valid,
    input  logic               snp_inv,
    input  logic [IW-1:0]      snp_idx,
    input  logic [WORDS-1:0]   snp_mask,
    input  logic               fill_valid,
    input  logic               fill_shared,
    output logic               req_valid,
    output logic [IW-1:0]      req_base,
    output logic [WORDS-1:0]   req_mask,
    output logic               inv_valid,
    output logic [IW-1:0]      inv_idx,
    output logic               fetch_busy,
    output logic [2*WORDS-1:0] word_state,
    output logic [1:0]         blk_attr,
    output logic [KW-1:0]      sub_k,
    output logic [CONF_W-1:0]  conf
);
    logic [2*WORDS-1:0] st_flat;
    logic [WORDS-1:0]   valid_vec;
    logic [WORDS-1:0]   pend_mask;
    logic               snp_hit;
    logic               fill_go;
    logic               busy;
    battr_e             attr;
    logic [1:0]         cur_st;
    logic               accept;
    logic               miss_go;
    logic               wr_go;
    logic               inv_q;
    logic [IW-1:0]      inv_idx_q;

    assign cur_st  = st_flat[2*loc_idx +: 2];
    assign accept  = loc_valid && !busy && !snp_valid;
    assign miss_go = accept && (cur_st == W_I);
    assign wr_go   = accept && loc_write && (cur_st != W_I);

    line_state_array #(.WORDS(WORDS)) u_state (
        .clk         (clk),
        .rst         (rst),
        .wr_go       (wr_go),
        .wr_idx      (loc_idx),
        .fill_go     (fill_go),
        .fill_mask   (pend_mask),
        .fill_shared (fill_shared),
        .snp_valid   (snp_valid),
        .snp_inv     (snp_inv),
        .snp_mask    (snp_mask),
        .st_flat     (st_flat),
        .valid_vec   (valid_vec),
        .snp_hit     (snp_hit),
        .attr_q      (attr)
    );

    fetch_gather #(.WORDS(WORDS)) u_gather (
        .clk         (clk),
        .rst         (rst),
        .miss_go     (miss_go),
        .miss_idx    (loc_idx),
        .k           (sub_k),
        .inval_vec   (~valid_vec),
        .fill_valid  (fill_valid),
        .fill_go     (fill_go),
        .busy_q      (busy),
        .pend_q      (pend_mask),
        .req_valid_q (req_valid),
        .req_base_q  (req_base),
        .req_mask_q  (req_mask)
    );

    subblock_sizer #(.WORDS(WORDS), .CONF_W(CONF_W), .K_INIT(K_INIT)) u_sizer (
        .clk      (clk),
        .rst      (rst),
        .snp_hit  (snp_hit),
        .snp_idx  (snp_idx),
        .snp_mask (snp_mask),
        .k_q      (sub_k),
        .conf_q   (conf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q     <= 1'b0;
            inv_idx_q <= '0;
        end else begin
            inv_q     <= wr_go && (cur_st == W_S);
            inv_idx_q <= loc_idx;
        end
    end

    assign inv_valid  = inv_q;
    assign inv_idx    = inv_idx_q;
    assign fetch_busy = busy;
    assign word_state = st_flat;
    assign blk_attr   = attr;

    // R5: the upgraded word is modified when its invalidate goes out
    a_r5_upgrade_owned: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (word_state[2*inv_idx +: 2] == W_M));

    // R3: a local access colliding with a snoop issues nothing
    a_r3_snoop_blocks_local: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && snp_valid) |=> (!req_valid && !inv_valid));

endmodule

// File: tb/test_subfetch_line.sv
module test_subfetch_line;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       loc_valid = 0, loc_write = 0;
    logic [2:0] loc_idx = 0;
    logic       snp_valid = 0, snp_inv = 0;
    logic [2:0] snp_idx = 0;
    logic [7:0] snp_mask = 0;
    logic       fill_valid = 0, fill_shared = 0;
    logic       req_valid, inv_valid, fetch_busy;
    logic [2:0] req_base, inv_idx;
    logic [7:0] req_mask;
    logic [15:0] word_state;
    logic [1:0] blk_attr, sub_k, conf;

    int checks = 0;
    int errors = 0;

    // model of the requirements
    int   m_st [W];
    int   m_attr, m_k, m_conf;
    bit   m_dir_grow, m_busy;
    int   m_pend;
    bit   e_req, e_inv;
    int   e_base, e_mask, e_inv_idx;
    bit   t_local_blocked, t_voted;

    always #(CLK_PERIOD/2) clk = ~clk;

    subfetch_line i_subfetch_line (
        .clk(clk), .rst(rst),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_idx(loc_idx),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_idx(snp_idx), .snp_mask(snp_mask),
        .fill_valid(fill_valid), .fill_shared(fill_shared),
        .req_valid(req_valid), .req_base(req_base), .req_mask(req_mask),
        .inv_valid(inv_valid), .inv_idx(inv_idx), .fetch_busy(fetch_busy),
        .word_state(word_state), .blk_attr(blk_attr), .sub_k(sub_k), .conf(conf)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int span_of(input int base, input int len);
        int m = 0;
        for (int j = 0; j < W; j++) if (j >= base && j < base + len) m |= (1 << j);
        return m;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; loc_valid = 0; snp_valid = 0; fill_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int j = 0; j < W; j++) m_st[j] = 0;
        m_attr = 0; m_k = 1; m_conf = 0; m_dir_grow = 0; m_busy = 0; m_pend = 0;
        @(negedge clk);
        check(word_state == 16'h0, "R1 word states", int'(word_state), 0);
        check(blk_attr == 2'd0, "R1 attr", int'(blk_attr), 0);
        check(sub_k == 2'd1, "R1 sub_k", int'(sub_k), 1);
        check(conf == 2'd0, "R1 conf", int'(conf), 0);
        check(!fetch_busy && !req_valid && !inv_valid, "R1 idle outputs",
              int'({fetch_busy, req_valid, inv_valid}), 0);
    endtask

    task automatic model_step(input bit L, input bit lw, input int li, input bit S, input bit si_inv,
                              input int si, input int sm, input bit F, input bit fs);
        int  ns [W];
        int  na, sbase, sspan, lmask, lbase;
        bit  hit, acc, fgo, all_i;
        int  vote; // 0 none, 1 shrink, 2 grow
        hit = 0;
        for (int j = 0; j < W; j++) begin
            ns[j] = m_st[j];
            if (sm[j] && S && m_st[j] != 0) hit = 1;
        end
        na = m_attr; e_req = 0; e_inv = 0;
        acc = L && !m_busy && !S;
        t_local_blocked = L && !acc;
        fgo = F && m_busy;
        if (acc) begin
            if (m_st[li] == 0) begin
                lbase = li & ~((1 << m_k) - 1);
                lmask = 0;
                for (int j = 0; j < W; j++)
                    if (j >= lbase && j < lbase + (1 << m_k) && m_st[j] == 0) lmask |= (1 << j);
                e_req = 1; e_base = lbase; e_mask = lmask;
                m_busy = 1; m_pend = lmask;
            end else if (lw) begin
                if (m_st[li] == 1) begin e_inv = 1; e_inv_idx = li; end
                ns[li] = 3;
            end
        end
        if (fgo) begin
            for (int j = 0; j < W; j++) if (m_pend[j]) ns[j] = fs ? 1 : 2;
            na = (fs || m_attr == 1) ? 1 : 2;
            m_busy = 0;
        end
        if (S) for (int j = 0; j < W; j++)
            if (sm[j]) ns[j] = si_inv ? 0 : (ns[j] != 0 ? 1 : 0);
        if (S && !si_inv && hit) na = 1;
        all_i = 1;
        for (int j = 0; j < W; j++) if (ns[j] != 0) all_i = 0;
        if (all_i) na = 0;
        vote = 0;
        if (S && hit) begin
            sbase = si & ~((1 << m_k) - 1);
            sspan = span_of(sbase, 1 << m_k);
            if ((sm & ~sspan & 8'hFF) != 0) vote = 1;
            else if ((sm & sspan) == sspan) vote = 2;
        end
        t_voted = (vote != 0);
        if (vote != 0) begin
            if ((vote == 2) == m_dir_grow) begin
                if (m_conf == 3) begin
                    m_conf = 0;
                    if (vote == 2 && m_k < 3) m_k++;
                    else if (vote == 1 && m_k > 0) m_k--;
                end else m_conf++;
            end else begin
                m_conf = 0; m_dir_grow = (vote == 2);
            end
        end
        for (int j = 0; j < W; j++) m_st[j] = ns[j];
        m_attr = na;
    endtask

    task automatic compare_all();
        for (int j = 0; j < W; j++)
            check(int'(word_state[2*j +: 2]) == m_st[j], $sformatf("R4/R5/R6 word %0d state", j),
                  int'(word_state[2*j +: 2]), m_st[j]);
        check(int'(blk_attr) == m_attr, "R7 block attribute", int'(blk_attr), m_attr);
        check(int'(sub_k) == m_k, t_voted ? "R8 sub_k after vote" : "R9 sub_k", int'(sub_k), m_k);
        check(int'(conf) == m_conf, t_voted ? "R8 conf after vote" : "R9 conf", int'(conf), m_conf);
        check(fetch_busy == m_busy, "R4 fetch_busy", int'(fetch_busy), int'(m_busy));
        check(req_valid == e_req, t_local_blocked ? "R3 blocked local req" : "R2 req_valid",
              int'(req_valid), int'(e_req));
        if (e_req) begin
            check(int'(req_base) == e_base, "R2 req_base", int'(req_base), e_base);
            check(int'(req_mask) == e_mask, "R2 req_mask", int'(req_mask), e_mask);
        end
        check(inv_valid == e_inv, t_local_blocked ? "R3 blocked local inv" : "R5 inv_valid",
              int'(inv_valid), int'(e_inv));
        if (e_inv) check(int'(inv_idx) == e_inv_idx, "R5 inv_idx", int'(inv_idx), e_inv_idx);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int round = 0; round < 6; round++) begin
            do_reset();
            for (int cyc = 0; cyc < 600; cyc++) begin
                int  phase, sel, sz, sidx, smask;
                bit  L, lw, S, sinv, F, fs;
                int  li;
                phase = (cyc / 150 + round) % 4;
                L  = ($urandom % 2) == 0;
                lw = ($urandom % 2) == 0;
                li = $urandom % W;
                S  = (phase == 1 || phase == 2) ? (($urandom % 2) == 0) : (($urandom % 4) == 0);
                sinv = (phase == 1 || phase == 2) ? (($urandom % 8) == 0) : (($urandom % 3) == 0);
                sidx = $urandom % W;
                F  = ($urandom % 3) == 0;
                fs = ($urandom % 2) == 0;
                if (phase == 1) begin
                    smask = span_of(sidx & ~((1 << m_k) - 1), 1 << m_k);
                end else if (phase == 2) begin
                    smask = (m_k < 3) ? 8'hFF : (1 << sidx);
                end else begin
                    sel = $urandom % 4;
                    sz = 1 << ($urandom % 4);
                    case (sel)
                        0: smask = 1 << sidx;
                        1: smask = span_of(sidx & ~(sz - 1), sz);
                        2: smask = $urandom % 256;
                        default: smask = 8'hFF;
                    endcase
                end
                loc_valid = L; loc_write = lw; loc_idx = 3'(li);
                snp_valid = S; snp_inv = sinv; snp_idx = 3'(sidx); snp_mask = 8'(smask);
                fill_valid = F; fill_shared = fs;
                model_step(L, lw, li, S, sinv, sidx, smask, F, fs);
                @(negedge clk);
                compare_all();
            end
        end
        loc_valid = 0; snp_valid = 0; fill_valid = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule